// File: doc/BRIEF.md
# Banked Framebuffer Aperture

The block sits between a 128 KB host memory window and a much larger video RAM. It turns single-byte host reads and writes into accesses on a 32-bit synchronous video RAM port. A bank number selects which 64 KB slice of video RAM the window reaches. Separate bank values are kept for reads and for writes, so a copy can read from one slice and write to another.

Two layouts are supported. In the chained layout, each host byte is one video RAM byte. In the planar layout, each host byte offset selects one 32-bit word, and the four byte lanes of that word act as four planes. A 4-bit plane mask chooses which planes take part in a write. On a read, the bytes of the selected planes are ORed together. Every address wraps modulo the video RAM size. Host addresses in the upper half of the window touch nothing.

Top module: `fb_aperture`

## Requirements
- R1: A host access with `host_addr[16]` set causes no video RAM access. Such a write is lost. Such a read still pulses `host_rvalid` and returns `8'h00`.
- R2: In chained mode (`chain_mode`=1), the byte address is `host_addr[15:0] + bank*65536`. `vram_addr` is that byte address shifted right by 2. A write drives the single byte enable `1 << byte_address[1:0]` and replicates the data byte to all four lanes. A read returns lane `byte_address[1:0]`, where lane i is `vram_rdata[8i+7:8i]`.
- R3: In planar mode (`chain_mode`=0), a write targets word `host_addr[15:0] + bank*16384`, which is byte `offset*4 + plane + bank*65536` for each plane. Plane i is byte lane i. `vram_be` equals `map_mask`. If the mask is zero, no video RAM access is made.
- R4: In planar mode, a read returns the bitwise OR of the lanes whose `map_mask` bit is set. With a zero mask it returns `8'h00`.
- R5: All video RAM addresses wrap modulo 2^`VRAM_LOG2` bytes, so bank b and bank b + 2^(`VRAM_LOG2`-16) alias.
- R6: Writes use `wr_bank` and reads use `rd_bank`. The other bank value has no effect on the access.
- R7: Read data and a one-cycle `host_rvalid` pulse appear in the cycle after a read strobe. `host_rvalid` is never raised otherwise.
- R8: When `host_wr` and `host_rd` are high together, the write is performed and the read is dropped, with no `host_rvalid`.
- R9: While reset is held, and with no strobes after it, `host_rvalid` and `vram_en` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 17 | Byte offset within the host window |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| rd_bank | input | BANK_W | Bank used by reads |
| wr_bank | input | BANK_W | Bank used by writes |
| chain_mode | input | 1 | 1 = chained layout, 0 = planar layout |
| map_mask | input | 4 | Plane enables for planar accesses |
| host_rdata | output | 8 | Read result, valid with host_rvalid |
| host_rvalid | output | 1 | Read result strobe |
| vram_en | output | 1 | Video RAM access enable |
| vram_we | output | 1 | Video RAM write enable |
| vram_addr | output | VRAM_LOG2-2 | Video RAM word address |
| vram_be | output | 4 | Video RAM byte enables |
| vram_wdata | output | 32 | Video RAM write word |
| vram_rdata | input | 32 | Video RAM read word, one cycle after vram_en |

## Verification
The bench builds the block with `VRAM_LOG2`=20 (1 MB) and `BANK_W`=6. Only 16 banks are then distinct, so banks 16 to 19 alias banks 0 to 3. Random traffic therefore hits the wraparound of R5 often, and writes through one bank are seen through its alias. Planar offsets near 0xFFFF carry into the next bank's word range, and random strokes let chained and planar accesses overlap on the same words.

// File: rtl/fb_aperture_pkg.sv
package fb_aperture_pkg;

    // Context of a read, held for one cycle while video RAM answers
    typedef struct packed {
        logic       valid;
        logic       drop;
        logic       chain;
        logic [1:0] lane;
        logic [3:0] mask;
    } rd_ctx_t;

    localparam int LANES = 4;

    function automatic logic [3:0] lane_onehot(input logic [1:0] lane);
        logic [3:0] r;
        r = 4'b0001 << lane;
        return r;
    endfunction

    function automatic logic [7:0] merge_planes(input logic [31:0] word, input logic [3:0] mask);
        logic [7:0] acc;
        acc = 8'h00;
        for (int i = 0; i < LANES; i++) begin
            if (mask[i]) acc = acc | word[8*i +: 8];
        end
        return acc;
    endfunction

    function automatic logic [7:0] pick_lane(input logic [31:0] word, input logic [1:0] lane);
        return word[8*lane +: 8];
    endfunction

endpackage

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
    import fb_aperture_pkg::*;
#(
    parameter int VRAM_LOG2 = 22,
    parameter int BANK_W    = 6
) (
    input  logic [15:0]             offset,
    input  logic [BANK_W-1:0]       bank,
    input  logic                    chain,
    output logic [VRAM_LOG2-3:0]    word_addr,
    output logic [1:0]              lane
);
    localparam int KB      = VRAM_LOG2 - 16;
    localparam int WORD_AW = VRAM_LOG2 - 2;

    logic [KB-1:0]        bank_k;
    logic [VRAM_LOG2-1:0] chain_byte;
    logic [WORD_AW-1:0]   planar_word;

    generate
        if (BANK_W >= KB) begin : g_bank_trunc
            assign bank_k = bank[KB-1:0];
        end else begin : g_bank_ext
            assign bank_k = {{(KB-BANK_W){1'b0}}, bank};
        end
    endgenerate

    // Truncation to the VRAM width performs the wrap
    assign chain_byte  = {bank_k, 16'h0000} + {{KB{1'b0}}, offset};
    assign planar_word = {bank_k, 14'h0000} + {{(KB-2){1'b0}}, offset};

    always_comb begin
        if (chain) begin
            word_addr = chain_byte[VRAM_LOG2-1:2];
            lane      = chain_byte[1:0];
        end else begin
            word_addr = planar_word;
            lane      = 2'b00;
        end
    end

endmodule

// File: rtl/fb_read_merge.sv
module fb_read_merge
    import fb_aperture_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  rd_ctx_t     ctx_d,
    input  logic [31:0] vram_rdata,
    output logic [7:0]  host_rdata,
    output logic        host_rvalid
);
    rd_ctx_t ctx_q;

    always_ff @(posedge clk) begin
        if (rst) ctx_q <= '0;
        else     ctx_q <= ctx_d;
    end

    always_comb begin
        if (!ctx_q.valid || ctx_q.drop) host_rdata = 8'h00;
        else if (ctx_q.chain)           host_rdata = pick_lane(vram_rdata, ctx_q.lane);
        else                            host_rdata = merge_planes(vram_rdata, ctx_q.mask);
    end

    assign host_rvalid = ctx_q.valid;

    // R7: a captured read request always produces a result strobe
    p_ctx_to_rvalid_r7: assert property (@(posedge clk) disable iff (rst)
        ctx_d.valid |=> host_rvalid);

    // R7: outside a read result the data bus is quiet
    p_quiet_data_r7: assert property (@(posedge clk) disable iff (rst)
        !host_rvalid |-> host_rdata == 8'h00);

endmodule

// File: rtl/fb_aperture.sv
module fb_aperture
    import fb_aperture_pkg::*;
#(
    parameter int VRAM_LOG2 = 22,
    parameter int BANK_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [16:0]          host_addr,
    input  logic [7:0]           host_wdata,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [BANK_W-1:0]    rd_bank,
    input  logic [BANK_W-1:0]    wr_bank,
    input  logic                 chain_mode,
    input  logic [3:0]           map_mask,
    output logic [7:0]           host_rdata,
    output logic                 host_rvalid,
    output logic                 vram_en,
    output logic                 vram_we,
    output logic [VRAM_LOG2-3:0] vram_addr,
    output logic [3:0]           vram_be,
    output logic [31:0]          vram_wdata,
    input  logic [31:0]          vram_rdata
);
    logic              upper_half;
    logic              do_wr;
    logic              do_rd;
    logic [BANK_W-1:0] bank_sel;
    logic [1:0]        lane;
    rd_ctx_t           ctx_d;

    assign upper_half = host_addr[16];
    // Write wins when both strobes are raised
    assign do_wr      = host_wr && !upper_half;
    assign do_rd      = host_rd && !host_wr && !upper_half;
    assign bank_sel   = host_wr ? wr_bank : rd_bank;

    fb_addr_gen #(
        .VRAM_LOG2 (VRAM_LOG2),
        .BANK_W    (BANK_W)
    ) i_addr_gen (
        .offset    (host_addr[15:0]),
        .bank      (bank_sel),
        .chain     (chain_mode),
        .word_addr (vram_addr),
        .lane      (lane)
    );

    always_comb begin
        vram_we    = do_wr && (chain_mode || (map_mask != 4'h0));
        vram_en    = vram_we || do_rd;
        vram_wdata = {4{host_wdata}};
        if (!vram_we)        vram_be = 4'h0;
        else if (chain_mode) vram_be = lane_onehot(lane);
        else                 vram_be = map_mask;
    end

    always_comb begin
        ctx_d.valid = host_rd && !host_wr;
        ctx_d.drop  = upper_half;
        ctx_d.chain = chain_mode;
        ctx_d.lane  = lane;
        ctx_d.mask  = map_mask;
    end

    fb_read_merge i_read_merge (
        .clk         (clk),
        .rst         (rst),
        .ctx_d       (ctx_d),
        .vram_rdata  (vram_rdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    p_upper_write_dropped_r1: assert property (@(posedge clk) disable iff (rst)
        host_wr && host_addr[16] |-> !vram_en);

    p_upper_read_zero_r1: assert property (@(posedge clk) disable iff (rst)
        host_rd && !host_wr && host_addr[16] |=> host_rvalid && host_rdata == 8'h00);

    p_chain_single_lane_r2: assert property (@(posedge clk) disable iff (rst)
        vram_we && chain_mode |-> $countones(vram_be) == 1);

    p_planar_write_enables_r3: assert property (@(posedge clk) disable iff (rst)
        vram_we |-> vram_be != 4'h0);

    p_mask_zero_read_r4: assert property (@(posedge clk) disable iff (rst)
        host_rd && !host_wr && !chain_mode && map_mask == 4'h0 |=> host_rdata == 8'h00);

    p_read_latency_r7: assert property (@(posedge clk) disable iff (rst)
        host_rd && !host_wr |=> host_rvalid);

    p_no_spurious_rvalid_r7: assert property (@(posedge clk) disable iff (rst)
        !(host_rd && !host_wr) |=> !host_rvalid);

    p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
        host_wr |-> !(vram_en && !vram_we));

endmodule

// File: tb/test_fb_aperture.sv
`timescale 1ns/1ps
module test_fb_aperture;
    localparam int VLOG  = 20;
    localparam int BW    = 6;
    localparam int VSIZE = 1 << VLOG;
    localparam int WORDS = VSIZE / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [BW-1:0] rd_bank = '0;
    logic [BW-1:0] wr_bank = '0;
    logic        chain_mode = 1'b1;
    logic [3:0]  map_mask = 4'hF;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        vram_en;
    logic        vram_we;
    logic [VLOG-3:0] vram_addr;
    logic [3:0]  vram_be;
    logic [31:0] vram_wdata;
    logic [31:0] vram_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fb_aperture #(.VRAM_LOG2(VLOG), .BANK_W(BW)) i_fb_aperture (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .rd_bank(rd_bank), .wr_bank(wr_bank),
        .chain_mode(chain_mode), .map_mask(map_mask), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .vram_en(vram_en), .vram_we(vram_we),
        .vram_addr(vram_addr), .vram_be(vram_be), .vram_wdata(vram_wdata),
        .vram_rdata(vram_rdata)
    );

    // Video RAM model: synchronous, one cycle read latency
    logic [31:0] vmem [int];
    always @(posedge clk) begin
        if (vram_en) begin
            logic [31:0] w;
            w = vmem.exists(int'(vram_addr)) ? vmem[int'(vram_addr)] : 32'h0;
            if (vram_we) begin
                for (int i = 0; i < 4; i++)
                    if (vram_be[i]) w[8*i +: 8] = vram_wdata[8*i +: 8];
                vmem[int'(vram_addr)] = w;
            end else begin
                vram_rdata <= w;
            end
        end
    end

    // Reference byte memory
    logic [7:0] refm [int];

    function automatic logic [7:0] ref_get(input int b);
        return refm.exists(b) ? refm[b] : 8'h00;
    endfunction

    function automatic int chain_byte(input int off, input int bank);
        return (off + bank * 65536) % VSIZE;
    endfunction

    function automatic int planar_byte(input int off, input int plane, input int bank);
        return (off * 4 + plane + bank * 65536) % VSIZE;
    endfunction

    function automatic logic [7:0] ref_read(input logic [16:0] a, input int bank,
                                           input logic ch, input logic [3:0] m);
        logic [7:0] r;
        r = 8'h00;
        if (a[16]) return 8'h00;
        if (ch) return ref_get(chain_byte(int'(a[15:0]), bank));
        for (int i = 0; i < 4; i++)
            if (m[i]) r = r | ref_get(planar_byte(int'(a[15:0]), i, bank));
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One host operation starting at a negedge
    task automatic host_op(input bit wr, input bit rd, input logic [16:0] a,
                           input logic [7:0] d, input int rb, input int wb,
                           input logic ch, input logic [3:0] m, input string req);
        int off;
        off = int'(a[15:0]);
        host_addr = a; host_wdata = d; host_wr = wr; host_rd = rd;
        rd_bank = BW'(rb); wr_bank = BW'(wb); chain_mode = ch; map_mask = m;
        #1;
        if (wr) begin
            bit exp_en;
            int exp_addr;
            int exp_be;
            exp_en = !a[16] && (ch || m != 4'h0);
            if (ch) begin
                exp_addr = chain_byte(off, wb) / 4;
                exp_be   = 1 << (chain_byte(off, wb) % 4);
            end else begin
                exp_addr = (off + wb * 16384) % WORDS;
                exp_be   = int'(m);
            end
            check(vram_en == exp_en && vram_we == exp_en, req, "write enable",
                  int'(vram_en), int'(exp_en));
            if (exp_en) begin
                check(int'(vram_addr) == exp_addr, req, "write word address",
                      int'(vram_addr), exp_addr);
                check(int'(vram_be) == exp_be, req, "byte enables", int'(vram_be), exp_be);
                check(vram_wdata == {4{d}}, req, "write data", int'(vram_wdata), int'({4{d}}));
            end
            if (!a[16]) begin
                if (ch) refm[chain_byte(off, wb)] = d;
                else for (int i = 0; i < 4; i++)
                    if (m[i]) refm[planar_byte(off, i, wb)] = d;
            end
        end
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        if (rd && !wr) begin
            logic [7:0] e;
            e = ref_read(a, rb, ch, m);
            check(host_rvalid == 1'b1, req, "read valid", int'(host_rvalid), 1);
            check(host_rdata == e, req, "read data", int'(host_rdata), int'(e));
        end else begin
            check(host_rvalid == 1'b0, req, "no read valid", int'(host_rvalid), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        check(host_rvalid == 1'b0, "R9", "rvalid in reset", int'(host_rvalid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(vram_en == 1'b0 && host_rvalid == 1'b0, "R9", "idle after reset",
              int'(vram_en), 0);

        // R2: chained write and read back in bank 0 and bank 3
        host_op(1, 0, 17'h00005, 8'hA5, 0, 0, 1, 4'h0, "R2");
        host_op(0, 1, 17'h00005, 8'h00, 0, 7, 1, 4'h0, "R2");
        host_op(1, 0, 17'h0FFFF, 8'h3C, 0, 3, 1, 4'hF, "R2");
        host_op(0, 1, 17'h0FFFF, 8'h00, 3, 0, 1, 4'hF, "R2");
        // R5: bank 17 aliases bank 1
        host_op(1, 0, 17'h00100, 8'h77, 0, 17, 1, 4'h0, "R5");
        host_op(0, 1, 17'h00100, 8'h00, 1, 0, 1, 4'h0, "R5");
        // R6: read bank differs from write bank
        host_op(1, 0, 17'h00200, 8'h11, 9, 2, 1, 4'h0, "R6");
        host_op(0, 1, 17'h00200, 8'h00, 2, 9, 1, 4'h0, "R6");
        host_op(0, 1, 17'h00200, 8'h00, 5, 2, 1, 4'h0, "R6");
        // R1: upper-half write dropped, upper-half read gives zero
        host_op(1, 0, 17'h10005, 8'hFF, 0, 0, 1, 4'h0, "R1");
        host_op(0, 1, 17'h00005, 8'h00, 0, 0, 1, 4'h0, "R1");
        host_op(0, 1, 17'h10005, 8'h00, 0, 0, 1, 4'h0, "R1");
        // R3: planar write with partial and zero mask
        host_op(1, 0, 17'h00040, 8'hC3, 0, 1, 0, 4'b0101, "R3");
        host_op(1, 0, 17'h00040, 8'h24, 0, 1, 0, 4'b0010, "R3");
        host_op(1, 0, 17'h00040, 8'hEE, 0, 1, 0, 4'b0000, "R3");
        // R4: planar reads OR selected planes; zero mask gives zero
        host_op(0, 1, 17'h00040, 8'h00, 1, 0, 0, 4'b0011, "R4");
        host_op(0, 1, 17'h00040, 8'h00, 1, 0, 0, 4'b0100, "R4");
        host_op(0, 1, 17'h00040, 8'h00, 1, 0, 0, 4'b0000, "R4");
        // R2/R3 overlap: chained read of a planar-written byte
        host_op(0, 1, 17'h00101, 8'h00, 17, 0, 1, 4'h0, "R2");
        // R5: planar offset crossing into the next bank, with wrap at bank 15
        host_op(1, 0, 17'h0FFFF, 8'h5A, 0, 15, 0, 4'b1000, "R5");
        host_op(0, 1, 17'h0FFFF, 8'h00, 31, 0, 0, 4'b1000, "R5");
        // R8: simultaneous strobes, write performed and read dropped
        host_op(1, 1, 17'h00300, 8'h99, 0, 0, 1, 4'h0, "R8");
        host_op(0, 1, 17'h00300, 8'h00, 0, 0, 1, 4'h0, "R8");
        // R7: back-to-back reads each return in the following cycle
        host_op(0, 1, 17'h00005, 8'h00, 0, 0, 1, 4'h0, "R7");
        host_op(0, 1, 17'h00300, 8'h00, 0, 0, 1, 4'h0, "R7");

        // Constrained random traffic
        void'($urandom(32'd1234));
        for (int k = 0; k < 800; k++) begin
            logic [16:0] a;
            int bsel[8];
            bit wr;
            bit rd;
            bsel = '{0, 1, 2, 3, 16, 17, 18, 19};
            a[16]    = ($urandom % 8) == 0;
            a[15:0]  = ($urandom % 2) ? 16'($urandom % 64) : 16'(16'hFFC0 + ($urandom % 64));
            wr = ($urandom % 2) == 1;
            rd = !wr || (($urandom % 16) == 0);
            host_op(wr, rd, a, 8'($urandom), bsel[$urandom % 8], bsel[$urandom % 8],
                    1'($urandom % 2), 4'($urandom), "R4");
        end

        finish_run();
    end
endmodule